// File: doc/BRIEF.md
# Dual Page Buffer with Role Swap

This block stages data between a host and a flash array using two equal page buffers of 256 bytes each. Each buffer is organised as 128 words of 16 bits. At any moment one buffer faces the host and the other is hidden from it. The host reads and writes the facing buffer through a plain synchronous port, either 16 bits at a time or one byte at a time. A one-cycle swap strobe exchanges the roles of the two buffers.

An identification upload strobe samples a revision byte and a configuration byte, which describes the present ready/busy output arrangement. It then writes these two bytes, together with a fixed proliferation code of 01h, into the hidden buffer, one byte per clock. While the upload runs, the busy flag is high. The host only sees the identification bytes after it issues a swap and then reads them.

Top module: `pgbuf_pair`

## Requirements
- R1: After reset, busy is low and no upload is in progress.
- R2: With word_mode high, a write stores all 16 bits of host_wdata into word host_addr[7:1] of the facing buffer. A read returns that whole word on host_rdata. host_addr[0] has no effect in this mode.
- R3: With word_mode low, host_addr[0]=0 selects bits [7:0] of word host_addr[7:1] and host_addr[0]=1 selects bits [15:8]. A write stores host_wdata[7:0] into the selected byte only, and host_wdata[15:8] is ignored. A read returns the selected byte on host_rdata[7:0] with host_rdata[15:8] zero.
- R4: Host writes never change the hidden buffer. A swap strobe with busy low exchanges the two roles, and a second swap restores the first mapping.
- R5: A swap takes effect at the clock edge that samples the strobe. A read or write issued in that same cycle uses the mapping from before the swap.
- R6: An upload strobe with busy low samples id_revision and id_config in that cycle. It then writes the revision to byte 0, 01h to byte 2 and the configuration to byte 4 of the hidden buffer. Every other byte of the hidden buffer is left unchanged, and changes to the id inputs after the strobe have no effect.
- R7: An upload leaves the facing buffer unchanged. The identification bytes become readable after a swap.
- R8: busy is high for exactly three cycles, starting in the cycle after the accepted upload strobe. An upload strobe sampled while busy is high is ignored.
- R9: A swap strobe sampled while busy is high does not change the mapping at once. It is held and takes effect at the edge that writes the last identification byte, so the mapping is exchanged when busy falls.
- R10: The host can read and write the facing buffer while an upload is running, with no effect on the upload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Byte address into the facing buffer |
| host_wdata | input | 16 | Write data |
| host_we | input | 1 | Write enable for the facing buffer |
| word_mode | input | 1 | 1 selects 16-bit access, 0 selects 8-bit access |
| host_rdata | output | 16 | Combinational read data from the facing buffer |
| swap_req | input | 1 | One-cycle strobe that exchanges buffer roles |
| upload_req | input | 1 | One-cycle strobe that starts an identification upload |
| id_revision | input | 8 | Revision byte sampled by the upload strobe |
| id_config | input | 8 | Ready/busy configuration byte sampled by the upload strobe |
| busy | output | 1 | High while an upload is in progress |

## Verification
Three kinds of fill are used. The first fills a buffer in word mode through odd addresses, which shows that bit 0 is ignored in that mode. The second fills through byte-mode writes that carry junk in the upper data byte, which shows that lanes are selected correctly and the upper byte is discarded. The third overwrites a few scattered single bytes, which shows that a byte write leaves its neighbour lane alone. Every fill is swept over all 128 words in word mode and all 256 bytes in byte mode, on both buffers across swaps. This tells apart a mixed-up bank, a swapped lane and a missing zero extension. Directed sequences then place a swap in the same cycle as a write, a swap and a host write inside an upload, changing id inputs during an upload, and a held upload strobe. These separate pre-swap from post-swap mapping, deferred from immediate swaps, and sampled from live identification values.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    localparam int PB_BYTES    = 256;
    localparam int PB_WORDS    = PB_BYTES / 2;
    localparam int BYTE_AW     = $clog2(PB_BYTES);
    localparam int WORD_AW     = $clog2(PB_WORDS);
    localparam int ID_COUNT    = 3;
    localparam int STEP_W      = $clog2(ID_COUNT);
    localparam logic [7:0] PROLIF_CODE = 8'h01;

    typedef logic [WORD_AW-1:0] waddr_t;

    typedef struct packed {
        logic              sel;
        logic              busy;
        logic [STEP_W-1:0] step;
        logic              pend;
        logic [7:0]        rev;
        logic [7:0]        cfg;
    } ctrl_st_t;
endpackage

// File: rtl/pgbuf_bank.sv
module pgbuf_bank #(
    parameter int WORDS = 128,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wd_lo,
    input  logic [7:0]    wd_hi,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [7:0] mem_lo [WORDS];
    logic [7:0] mem_hi [WORDS];

    always_ff @(posedge clk) begin
        if (we_lo) mem_lo[waddr] <= wd_lo;
        if (we_hi) mem_hi[waddr] <= wd_hi;
    end

    always_comb begin
        rdata = {mem_hi[raddr], mem_lo[raddr]};
    end

    // R2/R3: a stored byte is visible on the read port in the next cycle
    a_r2_lo_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && raddr == waddr) ##1 $stable(raddr) |-> rdata[7:0] == $past(wd_lo));
    a_r3_hi_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && raddr == waddr) ##1 $stable(raddr) |-> rdata[15:8] == $past(wd_hi));
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swap_req,
    input  logic       upload_req,
    input  logic [7:0] id_rev,
    input  logic [7:0] id_cfg,
    output logic       vis_sel,
    output logic       busy,
    output logic       up_we,
    output waddr_t     up_waddr,
    output logic [7:0] up_byte
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ID_COUNT - 1);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        up_we    = 1'b0;
        up_waddr = waddr_t'(st_q.step);
        case (st_q.step)
            STEP_W'(0): up_byte = st_q.rev;
            STEP_W'(1): up_byte = PROLIF_CODE;
            default:    up_byte = st_q.cfg;
        endcase
        if (st_q.busy) begin
            up_we = 1'b1;
            if (swap_req) st_d.pend = 1'b1;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
                if (st_q.pend || swap_req) begin
                    st_d.sel  = ~st_q.sel;
                    st_d.pend = 1'b0;
                end
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end else begin
            if (swap_req) st_d.sel = ~st_q.sel;
            if (upload_req) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.rev  = id_rev;
                st_d.cfg  = id_cfg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vis_sel = st_q.sel;
    assign busy    = st_q.busy;

    a_r8_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upload_req) |=> busy);
    a_r8_busy_multi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    a_r4_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && swap_req) |=> vis_sel != $past(vis_sel));
    a_r9_swap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.step != LAST_STEP) |=> $stable(vis_sel));
endmodule

// File: rtl/pgbuf_pair.sv
module pgbuf_pair
    import pgbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  host_addr,
    input  logic [15:0] host_wdata,
    input  logic        host_we,
    input  logic        word_mode,
    output logic [15:0] host_rdata,
    input  logic        swap_req,
    input  logic        upload_req,
    input  logic [7:0]  id_revision,
    input  logic [7:0]  id_config,
    output logic        busy
);
    logic       vis_sel;
    logic       up_we;
    waddr_t     up_waddr;
    logic [7:0] up_byte;
    waddr_t     h_word;
    logic       h_lane;
    logic       h_we_lo, h_we_hi;
    logic [7:0] h_d_lo, h_d_hi;
    logic [15:0] bank_rd [2];
    logic [15:0] vis_rd;

    pgbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_req   (swap_req),
        .upload_req (upload_req),
        .id_rev     (id_revision),
        .id_cfg     (id_config),
        .vis_sel    (vis_sel),
        .busy       (busy),
        .up_we      (up_we),
        .up_waddr   (up_waddr),
        .up_byte    (up_byte)
    );

    always_comb begin
        h_word  = host_addr[BYTE_AW-1:1];
        h_lane  = host_addr[0];
        h_we_lo = host_we & (word_mode | ~h_lane);
        h_we_hi = host_we & (word_mode | h_lane);
        h_d_lo  = host_wdata[7:0];
        h_d_hi  = word_mode ? host_wdata[15:8] : host_wdata[7:0];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic       we_lo, we_hi;
        waddr_t     waddr;
        logic [7:0] wd_lo, wd_hi;

        always_comb begin
            if (vis_sel == 1'(b)) begin
                we_lo = h_we_lo;
                we_hi = h_we_hi;
                waddr = h_word;
                wd_lo = h_d_lo;
                wd_hi = h_d_hi;
            end else begin
                we_lo = up_we;
                we_hi = 1'b0;
                waddr = up_waddr;
                wd_lo = up_byte;
                wd_hi = '0;
            end
        end

        pgbuf_bank #(.WORDS(PB_WORDS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (we_lo),
            .we_hi (we_hi),
            .waddr (waddr),
            .wd_lo (wd_lo),
            .wd_hi (wd_hi),
            .raddr (h_word),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        vis_rd = bank_rd[vis_sel];
        if (word_mode) host_rdata = vis_rd;
        else           host_rdata = {8'h00, h_lane ? vis_rd[15:8] : vis_rd[7:0]};
    end
endmodule

// File: tb/pgbuf_pair_test.sv
module pgbuf_pair_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_we = 1'b0;
    logic        word_mode = 1'b1;
    logic [15:0] host_rdata;
    logic        swap_req = 1'b0;
    logic        upload_req = 1'b0;
    logic [7:0]  id_revision = '0;
    logic [7:0]  id_config = '0;
    logic        busy;

    int checks = 0;
    int errors = 0;
    logic [15:0] m [2][128];
    int bv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgbuf_pair uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .word_mode(word_mode), .host_rdata(host_rdata),
        .swap_req(swap_req), .upload_req(upload_req), .id_revision(id_revision),
        .id_config(id_config), .busy(busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [15:0] d, input logic wm);
        @(negedge clk);
        host_addr = a; host_wdata = d; word_mode = wm; host_we = 1'b1;
        @(posedge clk); #1;
        host_we = 1'b0;
        if (wm) m[bv][a[7:1]] = d;
        else if (a[0]) m[bv][a[7:1]][15:8] = d[7:0];
        else m[bv][a[7:1]][7:0] = d[7:0];
    endtask

    task automatic hread(input logic [7:0] a, input logic wm, input string tag);
        logic [15:0] e;
        @(negedge clk);
        host_addr = a; word_mode = wm; host_we = 1'b0;
        #1;
        if (wm) e = m[bv][a[7:1]];
        else e = {8'h00, a[0] ? m[bv][a[7:1]][15:8] : m[bv][a[7:1]][7:0]};
        chk(tag, host_rdata, e);
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < 128; w++) begin
            hread(8'(2*w), 1'b1, {tag, " R2 word"});
            hread(8'(2*w+1), 1'b1, {tag, " R2 odd addr"});
        end
        for (int i = 0; i < 256; i++) hread(8'(i), 1'b0, {tag, " R3 byte"});
    endtask

    task automatic do_swap;
        @(negedge clk);
        swap_req = 1'b1;
        @(posedge clk); #1;
        swap_req = 1'b0;
        bv ^= 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int up;
        repeat (3) @(posedge clk);
        #1 chk("R1 busy after reset", 16'(busy), 16'h0);
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 busy released", 16'(busy), 16'h0);

        // word-mode fill of buffer A through odd addresses
        for (int w = 0; w < 128; w++)
            hwrite({7'(w), 1'b1}, 16'(w * 16'h0301 + 16'h1234), 1'b1);
        do_swap();
        // byte-mode fill of buffer B with junk in the upper data byte
        for (int i = 0; i < 256; i++)
            hwrite(8'(i), {8'hEE, 8'(i * 7 + 3)}, 1'b0);
        sweep("R4 bufB");
        do_swap();
        sweep("R4 bufA");
        // scattered byte overwrites keep the neighbour lane
        hwrite(8'h09, 16'hFF5A, 1'b0);
        hwrite(8'h10, 16'h00C3, 1'b0);
        hwrite(8'hFF, 16'h1177, 1'b0);
        hread(8'h08, 1'b1, "R3 lane keep");
        hread(8'h10, 1'b1, "R3 lane keep");
        hread(8'hFE, 1'b1, "R3 lane keep");
        do_swap();
        sweep("R4 bufB after A writes");
        do_swap();

        // R5: swap and write in the same cycle
        @(negedge clk);
        swap_req = 1'b1; host_we = 1'b1; host_addr = 8'h40; host_wdata = 16'hC0DE; word_mode = 1'b1;
        #1 chk("R5 read before swap edge", host_rdata, m[bv][8'h20]);
        @(posedge clk); #1;
        swap_req = 1'b0; host_we = 1'b0;
        m[bv][8'h20] = 16'hC0DE;
        bv ^= 1;
        hread(8'h40, 1'b1, "R5 post-swap mapping");
        do_swap();
        hread(8'h40, 1'b1, "R5 write hit pre-swap buffer");

        // upload with deferred swap and host write inside it
        up = bv ^ 1;
        @(negedge clk);
        upload_req = 1'b1; id_revision = 8'h3C; id_config = 8'h5A;
        #1 chk("R8 busy low before edge", 16'(busy), 16'h0);
        @(posedge clk); #1 chk("R8 busy cycle 1", 16'(busy), 16'h1);
        @(negedge clk);
        upload_req = 1'b0; id_revision = 8'hFF; id_config = 8'h00; swap_req = 1'b1;
        @(posedge clk); #1;
        swap_req = 1'b0;
        m[up][0][7:0] = 8'h3C;
        chk("R8 busy cycle 2", 16'(busy), 16'h1);
        host_addr = 8'h00; word_mode = 1'b0;
        #1 chk("R9 mapping held during upload", host_rdata, {8'h00, m[bv][0][7:0]});
        @(negedge clk);
        host_we = 1'b1; host_addr = 8'h28; host_wdata = 16'hBEEF; word_mode = 1'b1;
        @(posedge clk); #1;
        host_we = 1'b0;
        m[bv][8'h14] = 16'hBEEF;
        m[up][1][7:0] = 8'h01;
        chk("R8 busy cycle 3", 16'(busy), 16'h1);
        @(posedge clk); #1;
        m[up][2][7:0] = 8'h5A;
        chk("R8 busy falls after 3 cycles", 16'(busy), 16'h0);
        bv = up;
        hread(8'h00, 1'b0, "R6 revision byte 0");
        hread(8'h02, 1'b0, "R6 proliferation byte 2");
        hread(8'h04, 1'b0, "R6 config byte 4");
        chk("R6 sampled revision", 16'(m[bv][0][7:0]), 16'h003C);
        chk("R6 fixed code", 16'(m[bv][1][7:0]), 16'h0001);
        chk("R6 sampled config", 16'(m[bv][2][7:0]), 16'h005A);
        sweep("R6 R9 id buffer after deferred swap");
        do_swap();
        hread(8'h28, 1'b1, "R10 write during upload");
        sweep("R7 facing buffer untouched");

        // R8: held upload strobe is not re-accepted
        up = bv ^ 1;
        @(negedge clk);
        upload_req = 1'b1; id_revision = 8'h81; id_config = 8'h42;
        @(posedge clk); #1 chk("R8 held req busy 1", 16'(busy), 16'h1);
        @(posedge clk); #1 chk("R8 held req busy 2", 16'(busy), 16'h1);
        @(posedge clk); #1 chk("R8 held req busy 3", 16'(busy), 16'h1);
        @(posedge clk); #1 chk("R8 held req ignored", 16'(busy), 16'h0);
        @(negedge clk) upload_req = 1'b0;
        @(posedge clk); #1 chk("R8 idle after held req", 16'(busy), 16'h0);
        m[up][0][7:0] = 8'h81;
        m[up][1][7:0] = 8'h01;
        m[up][2][7:0] = 8'h42;
        sweep("R7 facing after second upload");
        do_swap();
        sweep("R6 second id upload");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule